// File: doc/BRIEF.md
# Memory Device Write Buffer Retire Model

This block is a cycle-based model, in synthesizable logic, of the single-entry write buffer that sits in front of the bank array of one memory device. Every clock cycle is one command slot. A column command in that slot is a write, a read or an idle slot. A write places bank, column, data and byte mask into the buffer. The buffered write is committed to the array (retired) later. The retire happens either because the device has seen enough consecutive idle slots, or because a newer write pushes it out.

Reads delay retirement. A read restarts the idle count. It also blocks the retire that the next slot's write would otherwise cause, so that second write overwrites the buffered entry and raises an error pulse. The buffer keeps no row address. For this reason the block tracks the open row of every bank from the activate and precharge inputs. Each retire reports the row that is open in the target bank at that moment, together with whether the bank is open at all. A user can therefore see when data lands in a row other than the one that was open when the write was issued.

Top module: `wbuf_retire`

## Requirements
- R1: The buffer holds at most one write. A retire reports the bank, column, data and byte mask that were captured by the write command that loaded the entry. All retire outputs and `overwrite_err` appear in the cycle after the command slot that causes them.
- R2: The buffer does not store a row. A retire reports the row held by the target bank's open-row register at the start of the retiring slot. An activate in that same slot only affects later slots.
- R3: A read command (`cmd_op` = 2'b10) never causes a retire. It restarts the idle count, so the auto-retire is postponed for as long as reads keep arriving.
- R4: A slot with no read and no write counts as idle. This covers `cmd_valid` = 0, `cmd_op` = 2'b00 and `cmd_op` = 2'b11. With an entry present, the retire fires on the RETIRE_DELAY-th consecutive idle slot after the last read or write. With the buffer empty, nothing is reported.
- R5: A write (`cmd_op` = 2'b01) arriving while the buffer is full retires the old entry in that slot and then loads the new one. This applies when the previous slot was not a read.
- R6: A write arriving while the buffer is full, with a read in the previous slot, overwrites the old entry without retiring it. It raises `overwrite_err` for one cycle.
- R7: `pend_bank` is one-hot at the bit of the buffered entry's bank while the buffer is full, and all zero while it is empty.
- R8: An activate opens a bank with the given row. A precharge closes it. When both name the same bank in one slot, the activate wins. `retire_row_open` reports whether the target bank was open when the retire happened.
- R9: Reset empties the buffer, closes every bank, clears the open rows and drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one command slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Column command present in this slot |
| cmd_op | input | 2 | 00 idle, 01 write, 10 read, 11 idle |
| cmd_bank | input | BANK_W | Target bank of the column command |
| cmd_col | input | COL_W | Target column of the column command |
| wr_data | input | DATA_W | Write data, captured with a write |
| wr_mask | input | MASK_W | Byte mask, captured with a write |
| act_valid | input | 1 | Activate a row in `act_bank` |
| act_bank | input | BANK_W | Bank to activate |
| act_row | input | ROW_W | Row opened by the activate |
| pre_valid | input | 1 | Precharge (close) `pre_bank` |
| pre_bank | input | BANK_W | Bank to close |
| retire_valid | output | 1 | One-cycle strobe: an entry was retired |
| retire_bank | output | BANK_W | Bank of the retired entry |
| retire_col | output | COL_W | Column of the retired entry |
| retire_row | output | ROW_W | Row open in that bank at retire time |
| retire_row_open | output | 1 | The target bank was open at retire time |
| retire_data | output | DATA_W | Data of the retired entry |
| retire_mask | output | MASK_W | Byte mask of the retired entry |
| overwrite_err | output | 1 | One-cycle pulse: a buffered entry was lost |
| pend_bank | output | NUM_BANKS | One-hot bank of the unretired entry |

## Verification
The bench builds the block with four banks, 3-bit columns, 4-bit rows, 8-bit data and RETIRE_DELAY of 3. With these values the idle count reaches its limit within a few slots. Every bank can be written, retired, precharged and reopened at every retire boundary. The bench sweeps idle gaps of zero to beyond the delay before a read, and all four op codes. It runs back-to-back writes with and without a preceding read, and activate, precharge or both in the retiring slot. Each result is compared with an arithmetic model of the requirements.

// File: rtl/wbuf_retire_pkg.sv
package wbuf_retire_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_SPARE = 2'b11
   } col_op_e;

   function automatic int bank_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wbuf_row_table.sv
module wbuf_row_table #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_valid,
   input  logic [BANK_W-1:0] act_bank,
   input  logic [ROW_W-1:0]  act_row,
   input  logic              pre_valid,
   input  logic [BANK_W-1:0] pre_bank,
   input  logic [BANK_W-1:0] rd_bank,
   output logic [ROW_W-1:0]  rd_row,
   output logic              rd_open
);

   logic [ROW_W-1:0]     row_q  [NUM_BANKS];
   logic [NUM_BANKS-1:0] open_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_act;
      logic hit_pre;
      assign hit_act = act_valid && (act_bank == BANK_W'(b));
      assign hit_pre = pre_valid && (pre_bank == BANK_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            row_q[b]  <= '0;
            open_q[b] <= 1'b0;
         end else if (hit_act) begin
            row_q[b]  <= act_row;
            open_q[b] <= 1'b1;
         end else if (hit_pre) begin
            open_q[b] <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_row  = '0;
      rd_open = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (rd_bank == BANK_W'(b)) begin
            rd_row  = row_q[b];
            rd_open = open_q[b];
         end
      end
   end

endmodule

// File: rtl/wbuf_retire_ctl.sv
module wbuf_retire_ctl #(
   parameter int RETIRE_DELAY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic is_wr,
   input  logic is_rd,
   input  logic buf_vld,
   output logic retire_fire,
   output logic overwrite
);

   localparam int CNT_W = $clog2(RETIRE_DELAY + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RETIRE_DELAY - 1);

   logic [CNT_W-1:0] idle_cnt_q;
   logic             hold_q;
   logic             idle;
   logic             auto_fire;
   logic             push_fire;

   assign idle      = !is_wr && !is_rd;
   assign auto_fire = buf_vld && idle && (idle_cnt_q == LAST);
   assign push_fire = buf_vld && is_wr && !hold_q;
   assign overwrite = buf_vld && is_wr && hold_q;
   assign retire_fire = auto_fire || push_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_cnt_q <= '0;
         hold_q     <= 1'b0;
      end else begin
         hold_q <= is_rd;
         if (!idle || retire_fire || !buf_vld)
            idle_cnt_q <= '0;
         else
            idle_cnt_q <= idle_cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wbuf_entry.sv
module wbuf_entry #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int COL_W     = 6,
   parameter int DATA_W    = 16,
   parameter int MASK_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 drop,
   input  logic [BANK_W-1:0]    in_bank,
   input  logic [COL_W-1:0]     in_col,
   input  logic [DATA_W-1:0]    in_data,
   input  logic [MASK_W-1:0]    in_mask,
   output logic                 vld,
   output logic [BANK_W-1:0]    bank,
   output logic [COL_W-1:0]     col,
   output logic [DATA_W-1:0]    data,
   output logic [MASK_W-1:0]    mask,
   output logic [NUM_BANKS-1:0] pend_bank
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         bank <= '0;
         col  <= '0;
         data <= '0;
         mask <= '0;
      end else if (load) begin
         vld  <= 1'b1;
         bank <= in_bank;
         col  <= in_col;
         data <= in_data;
         mask <= in_mask;
      end else if (drop) begin
         vld  <= 1'b0;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pend
      assign pend_bank[b] = vld && (bank == BANK_W'(b));
   end

endmodule

// File: rtl/wbuf_retire.sv
module wbuf_retire
   import wbuf_retire_pkg::*;
#(
   parameter  int NUM_BANKS    = 4,
   parameter  int COL_W        = 6,
   parameter  int ROW_W        = 9,
   parameter  int DATA_W       = 16,
   parameter  int RETIRE_DELAY = 3,
   localparam int BANK_W       = bank_bits(NUM_BANKS),
   localparam int MASK_W       = DATA_W / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [1:0]           cmd_op,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic [COL_W-1:0]     cmd_col,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [MASK_W-1:0]    wr_mask,
   input  logic                 act_valid,
   input  logic [BANK_W-1:0]    act_bank,
   input  logic [ROW_W-1:0]     act_row,
   input  logic                 pre_valid,
   input  logic [BANK_W-1:0]    pre_bank,
   output logic                 retire_valid,
   output logic [BANK_W-1:0]    retire_bank,
   output logic [COL_W-1:0]     retire_col,
   output logic [ROW_W-1:0]     retire_row,
   output logic                 retire_row_open,
   output logic [DATA_W-1:0]    retire_data,
   output logic [MASK_W-1:0]    retire_mask,
   output logic                 overwrite_err,
   output logic [NUM_BANKS-1:0] pend_bank
);

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("wbuf_retire: NUM_BANKS must be at least 1");
   end
   if (RETIRE_DELAY < 1) begin : g_bad_delay
      $error("wbuf_retire: RETIRE_DELAY must be at least 1");
   end
   if ((DATA_W < 8) || (DATA_W % 8 != 0)) begin : g_bad_data
      $error("wbuf_retire: DATA_W must be a positive multiple of 8");
   end
   if ((COL_W < 1) || (ROW_W < 1)) begin : g_bad_addr
      $error("wbuf_retire: COL_W and ROW_W must be positive");
   end

   col_op_e op;
   logic    is_wr;
   logic    is_rd;

   assign op    = col_op_e'(cmd_op);
   assign is_wr = cmd_valid && (op == OP_WRITE);
   assign is_rd = cmd_valid && (op == OP_READ);

   logic                buf_vld;
   logic [BANK_W-1:0]   buf_bank;
   logic [COL_W-1:0]    buf_col;
   logic [DATA_W-1:0]   buf_data;
   logic [MASK_W-1:0]   buf_mask;
   logic                fire;
   logic                ovw;
   logic [ROW_W-1:0]    tgt_row;
   logic                tgt_open;

   wbuf_retire_ctl #(
      .RETIRE_DELAY (RETIRE_DELAY)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .is_wr       (is_wr),
      .is_rd       (is_rd),
      .buf_vld     (buf_vld),
      .retire_fire (fire),
      .overwrite   (ovw)
   );

   wbuf_entry #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .COL_W     (COL_W),
      .DATA_W    (DATA_W),
      .MASK_W    (MASK_W)
   ) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (is_wr),
      .drop      (fire),
      .in_bank   (cmd_bank),
      .in_col    (cmd_col),
      .in_data   (wr_data),
      .in_mask   (wr_mask),
      .vld       (buf_vld),
      .bank      (buf_bank),
      .col       (buf_col),
      .data      (buf_data),
      .mask      (buf_mask),
      .pend_bank (pend_bank)
   );

   wbuf_row_table #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .ROW_W     (ROW_W)
   ) u_rows (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_valid (act_valid),
      .act_bank  (act_bank),
      .act_row   (act_row),
      .pre_valid (pre_valid),
      .pre_bank  (pre_bank),
      .rd_bank   (buf_bank),
      .rd_row    (tgt_row),
      .rd_open   (tgt_open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         retire_valid    <= 1'b0;
         retire_bank     <= '0;
         retire_col      <= '0;
         retire_row      <= '0;
         retire_row_open <= 1'b0;
         retire_data     <= '0;
         retire_mask     <= '0;
         overwrite_err   <= 1'b0;
      end else begin
         retire_valid  <= fire;
         overwrite_err <= ovw;
         if (fire) begin
            retire_bank     <= buf_bank;
            retire_col      <= buf_col;
            retire_row      <= tgt_row;
            retire_row_open <= tgt_open;
            retire_data     <= buf_data;
            retire_mask     <= buf_mask;
         end
      end
   end

endmodule

// File: rtl/wbuf_retire_chk.sv
module wbuf_retire_chk #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_valid,
   input logic [1:0]           cmd_op,
   input logic                 retire_valid,
   input logic [BANK_W-1:0]    retire_bank,
   input logic                 overwrite_err,
   input logic [NUM_BANKS-1:0] pend_bank
);

   logic c_wr;
   logic c_rd;
   logic prev_rd_q;

   assign c_wr = cmd_valid && (cmd_op == 2'b01);
   assign c_rd = cmd_valid && (cmd_op == 2'b10);

   always_ff @(posedge clk) begin
      if (!rst_n) prev_rd_q <= 1'b0;
      else        prev_rd_q <= c_rd;
   end

   p_read_no_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd |=> !retire_valid);

   p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_bank == '0) |=> (!retire_valid && !overwrite_err));

   p_push_retires_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_wr && (pend_bank != '0) && !prev_rd_q) |=> (retire_valid && !overwrite_err));

   p_overwrite_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_wr && (pend_bank != '0) && prev_rd_q) |=> (overwrite_err && !retire_valid));

   p_pend_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pend_bank));

   p_retire_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |-> ((($past(pend_bank) >> retire_bank) & NUM_BANKS'(1)) != '0));

endmodule

bind wbuf_retire wbuf_retire_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_op        (cmd_op),
   .retire_valid  (retire_valid),
   .retire_bank   (retire_bank),
   .overwrite_err (overwrite_err),
   .pend_bank     (pend_bank)
);

// File: tb/wbuf_retire_tb_top.sv
module wbuf_retire_tb_top;

   localparam int NB  = 4;
   localparam int CW  = 3;
   localparam int RW  = 4;
   localparam int DW  = 8;
   localparam int DLY = 3;
   localparam int BW  = 2;
   localparam int MW  = 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid;
   logic [1:0]    cmd_op;
   logic [BW-1:0] cmd_bank;
   logic [CW-1:0] cmd_col;
   logic [DW-1:0] wr_data;
   logic [MW-1:0] wr_mask;
   logic          act_valid;
   logic [BW-1:0] act_bank;
   logic [RW-1:0] act_row;
   logic          pre_valid;
   logic [BW-1:0] pre_bank;
   logic          retire_valid;
   logic [BW-1:0] retire_bank;
   logic [CW-1:0] retire_col;
   logic [RW-1:0] retire_row;
   logic          retire_row_open;
   logic [DW-1:0] retire_data;
   logic [MW-1:0] retire_mask;
   logic          overwrite_err;
   logic [NB-1:0] pend_bank;

   always #2.5 clk = ~clk;

   wbuf_retire #(
      .NUM_BANKS (NB), .COL_W (CW), .ROW_W (RW), .DATA_W (DW), .RETIRE_DELAY (DLY)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
      .cmd_bank (cmd_bank), .cmd_col (cmd_col), .wr_data (wr_data), .wr_mask (wr_mask),
      .act_valid (act_valid), .act_bank (act_bank), .act_row (act_row),
      .pre_valid (pre_valid), .pre_bank (pre_bank),
      .retire_valid (retire_valid), .retire_bank (retire_bank), .retire_col (retire_col),
      .retire_row (retire_row), .retire_row_open (retire_row_open),
      .retire_data (retire_data), .retire_mask (retire_mask),
      .overwrite_err (overwrite_err), .pend_bank (pend_bank)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   // reference state, derived from the requirements
   bit m_vld;
   int m_bank, m_col, m_data, m_mask, m_cnt;
   bit m_hold;
   bit m_open [NB];
   int m_row  [NB];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !done) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_vld = 0; m_bank = 0; m_col = 0; m_data = 0; m_mask = 0; m_cnt = 0; m_hold = 0;
      for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; end
   endtask

   // one command slot; called at a falling edge, returns at the next falling edge
   task automatic step(input int op, input int b, input int c, input int d, input int m,
                       input bit av, input int ab, input int ar,
                       input bit pv, input int pb, input string tag);
      bit is_wr, is_rd, idle, e_ret, e_ovw, e_open;
      int e_bank, e_col, e_data, e_mask, e_row, e_pend;
      cmd_valid = 1'b1;
      cmd_op    = 2'(op);
      cmd_bank  = BW'(b);
      cmd_col   = CW'(c);
      wr_data   = DW'(d);
      wr_mask   = MW'(m);
      act_valid = av; act_bank = BW'(ab); act_row = RW'(ar);
      pre_valid = pv; pre_bank = BW'(pb);
      is_wr = (op == 1);
      is_rd = (op == 2);
      idle  = !is_wr && !is_rd;
      e_ret = m_vld && ((idle && m_cnt == DLY - 1) || (is_wr && !m_hold));
      e_ovw = m_vld && is_wr && m_hold;
      e_bank = m_bank; e_col = m_col; e_data = m_data; e_mask = m_mask;
      e_row  = m_row[m_bank]; e_open = m_open[m_bank];
      @(posedge clk);
      #1;
      chk(tag, "retire_valid", retire_valid, e_ret);
      chk(e_ovw ? "R6" : tag, "overwrite_err", overwrite_err, e_ovw);
      if (e_ret) begin
         chk("R1", "retire_bank", retire_bank, e_bank);
         chk("R1", "retire_col",  retire_col,  e_col);
         chk("R1", "retire_data", retire_data, e_data);
         chk("R1", "retire_mask", retire_mask, e_mask);
         chk("R2", "retire_row",  retire_row,  e_row);
         chk("R8", "retire_row_open", retire_row_open, e_open);
      end
      // advance the reference state
      if (!idle || e_ret || !m_vld) m_cnt = 0; else m_cnt = m_cnt + 1;
      m_hold = is_rd;
      if (is_wr) begin
         m_vld = 1; m_bank = b; m_col = c; m_data = d; m_mask = m;
      end else if (e_ret) begin
         m_vld = 0;
      end
      if (pv) m_open[pb] = 0;
      if (av) begin m_open[ab] = 1; m_row[ab] = ar; end
      e_pend = m_vld ? (1 << m_bank) : 0;
      chk("R7", "pend_bank", pend_bank, e_pend);
      @(negedge clk);
   endtask

   task automatic idle_slot(input int op, input string tag);
      step(op, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic wr(input int b, input int c, input int d, input int m, input string tag);
      step(1, b, c, d, m, 0, 0, 0, 0, 0, tag);
   endtask

   task automatic row_op(input bit av, input int ab, input int ar, input bit pv, input int pb,
                         input string tag);
      step(0, 0, 0, 0, 0, av, ab, ar, pv, pb, tag);
   endtask

   initial begin
      rst_n = 1'b0;
      cmd_valid = 0; cmd_op = 0; cmd_bank = 0; cmd_col = 0; wr_data = 0; wr_mask = 0;
      act_valid = 0; act_bank = 0; act_row = 0; pre_valid = 0; pre_bank = 0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state at the ports
      chk("R9", "retire_valid", retire_valid, 0);
      chk("R9", "overwrite_err", overwrite_err, 0);
      chk("R9", "pend_bank", pend_bank, 0);
      chk("R9", "retire_row", retire_row, 0);
      chk("R9", "retire_row_open", retire_row_open, 0);
      rst_n = 1'b1;

      // R4: idle slots on an empty buffer report nothing, for every op code treated as idle
      idle_slot(0, "R4"); idle_slot(3, "R4");
      cmd_valid = 0; @(posedge clk); #1;
      chk("R4", "retire_valid (cmd_valid low, empty)", retire_valid, 0);
      @(negedge clk);

      // open a row in every bank
      for (int b = 0; b < NB; b++) row_op(1, b, 3 * b + 2, 0, 0, "R8");

      // R1/R4: sweep banks, columns and idle op codes through auto retire
      for (int b = 0; b < NB; b++) begin
         for (int c = 0; c < (1 << CW); c += 3) begin
            wr(b, c, 17 * b + 5 * c + 1, (b + c) & 1, "R1");
            for (int k = 0; k < DLY + 1; k++) idle_slot(((k + b) & 1) ? 3 : 0, "R4");
         end
      end

      // R3: reads after 0..DLY idle slots postpone the retire
      for (int g = 0; g <= DLY; g++) begin
         wr(1, g, 8'h40 + g, 1, "R3");
         for (int k = 0; k < g; k++) idle_slot(0, "R4");
         step(2, 2, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
         step(2, 3, 2, 0, 0, 0, 0, 0, 0, 0, "R3");
         for (int k = 0; k < DLY + 1; k++) idle_slot(3, "R3");
      end

      // R5: back-to-back writes push the older entry out
      wr(0, 1, 8'hA1, 1, "R5");
      wr(2, 6, 8'hB2, 0, "R5");
      wr(3, 7, 8'hC3, 1, "R5");
      for (int k = 0; k < DLY + 1; k++) idle_slot(0, "R4");

      // R6: a read just before the second write loses the first entry
      wr(1, 2, 8'h11, 1, "R6");
      step(2, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
      wr(2, 4, 8'h22, 0, "R6");
      for (int k = 0; k < DLY + 1; k++) idle_slot(0, "R6");

      // R2: retire lands in the row activated after the write
      wr(1, 5, 8'h5A, 1, "R2");
      step(2, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R2");
      step(2, 0, 0, 0, 0, 1, 1, 9, 0, 0, "R2");
      for (int k = 0; k < DLY + 1; k++) idle_slot(0, "R2");

      // R8: retire into a closed bank
      wr(2, 3, 8'h33, 0, "R8");
      row_op(0, 0, 0, 1, 2, "R8");
      for (int k = 0; k < DLY; k++) idle_slot(0, "R8");

      // R2: activate in the retiring slot affects later slots only
      wr(3, 1, 8'h77, 1, "R2");
      idle_slot(0, "R2"); idle_slot(0, "R2");
      row_op(1, 3, 14, 0, 0, "R2");
      // R8: activate and precharge of one bank together leave it open
      wr(0, 2, 8'h99, 1, "R8");
      row_op(1, 0, 6, 1, 0, "R8");
      idle_slot(0, "R8");
      idle_slot(0, "R8");
      idle_slot(0, "R8");

      // R9: reset in the middle of a pending entry
      wr(1, 1, 8'hEE, 1, "R9");
      rst_n = 1'b0;
      @(posedge clk); #1;
      chk("R9", "pend_bank after reset", pend_bank, 0);
      chk("R9", "retire_valid after reset", retire_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      for (int k = 0; k < DLY + 1; k++) idle_slot(0, "R9");
      wr(2, 0, 8'h12, 0, "R9");
      for (int k = 0; k < DLY; k++) idle_slot(0, "R8");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule